// File: doc/BRIEF.md
# Predicated Non-Faulting Vector Load Sequencer

This block fills one vector register from memory, one byte per element, and never turns a failed access into an exception. A start command supplies a 64-bit base, a signed 4-bit immediate, an element-size code, a per-byte governing predicate, the incoming per-byte first-fault mask and the old destination value. The block then visits the elements in increasing index order. For each active element it issues one byte read over a valid/ready request port and waits for a response that carries the data and a fault flag.

A fault is recorded rather than raised. From the faulting element onward, the first-fault mask is cleared. Any element at or after the first cleared mask entry is treated as uncertain and receives a fixed substitute value, which is zero by default. When the last element is finished, a single-cycle `done` pulse marks the new destination vector and the updated mask as valid on the outputs.

Top module: `nf_vload_seq`

## Requirements
- R1: Element e reads address base + (sext(imm) × N + e), where N is the element count for the current size and imm is a two's-complement value from -8 to 7. The immediate is scaled by N whether or not any element is active, and addresses wrap modulo 2^64.
- R2: An inactive element issues no read and never counts as a fault. Its whole element in the result is zero.
- R3: A known element receives its loaded byte in the lowest byte lane of the element (byte lane e × size_bytes, little-endian). All higher bytes of that element are zero.
- R4: `start_esz` selects the element size: 00 is 8-bit (16 elements at 128 bits), 01 is 16-bit, 10 is 32-bit and 11 is 64-bit. Element e is active when predicate bit e × size_bytes is 1; the other predicate bits in its group are ignored.
- R5: A fault is sticky. The first-fault mask bits of the whole byte group of the faulting element, and of every later element, are cleared to 0. Groups before the first fault keep their incoming values.
- R6: An element is uncertain once the lowest mask bit of its own group, or of any earlier group, is 0 after the fault update. This includes a 0 in the incoming mask. With the default fill policy, an uncertain element is written as zero. A 0 only in a non-lowest bit of a group has no effect on the data.
- R7: Reads are issued one at a time in increasing element order. A request stays valid with a stable address until it is accepted, and exactly one read is made per active element.
- R8: `busy` is high from the cycle after a start is accepted until the cycle in which `done` is high. `done` is a one-cycle pulse, with `result` and `ffr_out` valid in that cycle. A start presented while busy is ignored.
- R9: After reset, `busy`, `done` and `req_valid` are 0, and `result` and `ffr_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Start a load; accepted only when idle |
| start_base | input | 64 | Base byte address |
| start_imm | input | 4 | Signed vector-multiple offset |
| start_esz | input | 2 | Element size code |
| start_pred | input | VLEN/8 | Governing predicate, one bit per byte |
| start_ffr | input | VLEN/8 | Incoming first-fault mask, one bit per byte |
| start_old | input | VLEN | Old destination value |
| busy | output | 1 | Operation in progress |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 64 | Byte address of the read |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 8 | Returned byte |
| rsp_fault | input | 1 | The read was suppressed or faulted |
| done | output | 1 | One-cycle completion pulse |
| result | output | VLEN | New destination vector |
| ffr_out | output | VLEN/8 | Updated first-fault mask |

## Verification
The hardest case to reach from the ports is a fault window that covers only the address of an inactive element, while active elements that come later stay outside it. A wrong design that reads or faults on masked elements then shows up only through the mask and the data that follow. To reach it, the bench places a one-address fault range exactly on the address computed for an inactive element. Random runs also place a fault window at a random element position. In addition, a 0 is planted either in the lowest bit or in a higher bit of a group in the incoming mask, which separates the lowest-bit rule from a looser reading.

// File: rtl/nf_load_pkg.sv
package nf_load_pkg;

   typedef enum logic [1:0] {
      ESZ_BYTE  = 2'b00,
      ESZ_HALF  = 2'b01,
      ESZ_WORD  = 2'b10,
      ESZ_DWORD = 2'b11
   } esz_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_ISSUE = 2'b01,
      ST_WAIT  = 2'b10
   } seq_state_e;

   localparam int ADDR_W = 64;
   localparam int IMM_W  = 4;

endpackage

// File: rtl/nf_addr_gen.sv
module nf_addr_gen
   import nf_load_pkg::*;
#(
   parameter int VLEN = 128,
   parameter int IW   = 4
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IMM_W-1:0]  imm,
   input  logic [1:0]        esz,
   input  logic [IW-1:0]     idx,
   output logic [ADDR_W-1:0] addr
);
   localparam int LG_NB = $clog2(VLEN / 8);

   logic [ADDR_W-1:0] imm_x;
   logic [ADDR_W-1:0] scaled;

   // scale the signed offset by the element count: NB >> esz elements
   always_comb begin
      imm_x  = {{(ADDR_W - IMM_W){imm[IMM_W-1]}}, imm};
      scaled = imm_x << (LG_NB - int'(esz));
      addr   = base + scaled + ADDR_W'(idx);
   end
endmodule

// File: rtl/nf_lane_decode.sv
module nf_lane_decode #(
   parameter int NB = 16,
   parameter int IW = 4
) (
   input  logic [1:0]    esz,
   input  logic [IW-1:0] idx,
   input  logic [NB-1:0] pred,
   output logic [NB-1:0] grp,
   output logic [NB-1:0] lead,
   output logic          active
);
   logic [IW:0] lead_pos;

   assign lead_pos = {1'b0, idx} << esz;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      localparam logic [IW:0] BPOS = (IW + 1)'(b);
      assign grp[b]  = ((BPOS >> esz) == {1'b0, idx});
      assign lead[b] = (BPOS == lead_pos);
   end

   assign active = |(lead & pred);
endmodule

// File: rtl/nf_lane_update.sv
module nf_lane_update #(
   parameter int NB         = 16,
   parameter bit FILL_MERGE = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  logic [NB-1:0]   grp,
   input  logic [NB-1:0]   lead,
   input  logic [NB-1:0]   ffr_q,
   input  logic [NB*8-1:0] res_q,
   input  logic [NB*8-1:0] old_q,
   input  logic [7:0]      data,
   input  logic            fault,
   input  logic            faulted_q,
   input  logic            unknown_q,
   output logic [NB-1:0]   ffr_d,
   output logic [NB*8-1:0] res_d,
   output logic            faulted_d,
   output logic            unknown_d
);
   logic lead_ffr;

   assign faulted_d = faulted_q | fault;

   for (genvar b = 0; b < NB; b++) begin : g_ffr
      assign ffr_d[b] = (faulted_d && grp[b]) ? 1'b0 : ffr_q[b];
   end

   assign lead_ffr  = |(lead & ffr_d);
   assign unknown_d = unknown_q | ~lead_ffr;

   for (genvar b = 0; b < NB; b++) begin : g_res
      logic [7:0] fill;
      assign fill = FILL_MERGE ? old_q[b*8 +: 8] : 8'h00;
      always_comb begin
         if (!grp[b])        res_d[b*8 +: 8] = res_q[b*8 +: 8];
         else if (unknown_d) res_d[b*8 +: 8] = fill;
         else if (lead[b])   res_d[b*8 +: 8] = data;
         else                res_d[b*8 +: 8] = 8'h00;
      end
   end

   logic [NB*8-1:0] grp_bits;
   for (genvar b = 0; b < NB; b++) begin : g_gb
      assign grp_bits[b*8 +: 8] = {8{grp[b]}};
   end

   // R6: uncertain elements take zero under the default fill policy
   p_unknown_zero_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (step && unknown_d && !FILL_MERGE) |-> ((res_d & grp_bits) == '0));

   // R5: a fault in this element clears its own mask group
   p_fault_clears_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (step && fault) |-> ((ffr_d & grp) == '0));
endmodule

// File: rtl/nf_vload_seq.sv
module nf_vload_seq
   import nf_load_pkg::*;
#(
   parameter int VLEN       = 128,
   parameter bit FILL_MERGE = 1'b0,
   localparam int NB        = VLEN / 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_valid,
   input  logic [63:0]     start_base,
   input  logic [3:0]      start_imm,
   input  logic [1:0]      start_esz,
   input  logic [NB-1:0]   start_pred,
   input  logic [NB-1:0]   start_ffr,
   input  logic [VLEN-1:0] start_old,
   output logic            busy,
   output logic            req_valid,
   input  logic            req_ready,
   output logic [63:0]     req_addr,
   input  logic            rsp_valid,
   input  logic [7:0]      rsp_data,
   input  logic            rsp_fault,
   output logic            done,
   output logic [VLEN-1:0] result,
   output logic [NB-1:0]   ffr_out
);
   localparam int IW = $clog2(NB);

   if (VLEN < 128 || (VLEN % 64) != 0 || (VLEN & (VLEN - 1)) != 0) begin : g_bad_vlen
      $error("nf_vload_seq: VLEN must be a power of two, at least 128");
   end

   seq_state_e        state_q;
   logic [IW-1:0]     idx_q;
   logic [1:0]        esz_q;
   logic [63:0]       base_q;
   logic [3:0]        imm_q;
   logic [NB-1:0]     pred_q;
   logic [NB-1:0]     ffr_q;
   logic [VLEN-1:0]   res_q;
   logic [VLEN-1:0]   old_q;
   logic              faulted_q;
   logic              unknown_q;
   logic              done_q;

   logic [NB-1:0]     grp, lead;
   logic              active;
   logic [NB-1:0]     ffr_d;
   logic [VLEN-1:0]   res_d;
   logic              faulted_d, unknown_d;
   logic              step, last, start_go;
   logic [IW:0]       nel;
   logic [7:0]        elem_data;
   logic              elem_fault;

   nf_addr_gen #(.VLEN(VLEN), .IW(IW)) u_addr (
      .base (base_q),
      .imm  (imm_q),
      .esz  (esz_q),
      .idx  (idx_q),
      .addr (req_addr)
   );

   nf_lane_decode #(.NB(NB), .IW(IW)) u_dec (
      .esz    (esz_q),
      .idx    (idx_q),
      .pred   (pred_q),
      .grp    (grp),
      .lead   (lead),
      .active (active)
   );

   nf_lane_update #(.NB(NB), .FILL_MERGE(FILL_MERGE)) u_upd (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .grp       (grp),
      .lead      (lead),
      .ffr_q     (ffr_q),
      .res_q     (res_q),
      .old_q     (old_q),
      .data      (elem_data),
      .fault     (elem_fault),
      .faulted_q (faulted_q),
      .unknown_q (unknown_q),
      .ffr_d     (ffr_d),
      .res_d     (res_d),
      .faulted_d (faulted_d),
      .unknown_d (unknown_d)
   );

   assign nel        = (IW + 1)'(NB) >> esz_q;
   assign last       = ({1'b0, idx_q} == (nel - (IW + 1)'(1)));
   assign start_go   = (state_q == ST_IDLE) && start_valid;
   assign req_valid  = (state_q == ST_ISSUE) && active;
   assign step       = ((state_q == ST_ISSUE) && !active) ||
                       ((state_q == ST_WAIT) && rsp_valid);
   assign elem_data  = (state_q == ST_WAIT) ? rsp_data : 8'h00;
   assign elem_fault = (state_q == ST_WAIT) && rsp_fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         idx_q     <= '0;
         esz_q     <= '0;
         base_q    <= '0;
         imm_q     <= '0;
         pred_q    <= '0;
         ffr_q     <= '0;
         res_q     <= '0;
         old_q     <= '0;
         faulted_q <= 1'b0;
         unknown_q <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_go) begin
                  state_q   <= ST_ISSUE;
                  idx_q     <= '0;
                  esz_q     <= start_esz;
                  base_q    <= start_base;
                  imm_q     <= start_imm;
                  pred_q    <= start_pred;
                  ffr_q     <= start_ffr;
                  res_q     <= '0;
                  old_q     <= start_old;
                  faulted_q <= 1'b0;
                  unknown_q <= 1'b0;
               end
            end
            ST_ISSUE: begin
               if (active && req_ready) state_q <= ST_WAIT;
            end
            ST_WAIT: ;
            default: state_q <= ST_IDLE;
         endcase
         if (step) begin
            ffr_q     <= ffr_d;
            res_q     <= res_d;
            faulted_q <= faulted_d;
            unknown_q <= unknown_d;
            if (last) begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end else begin
               state_q <= ST_ISSUE;
               idx_q   <= idx_q + IW'(1);
            end
         end
      end
   end

   assign busy    = (state_q != ST_IDLE);
   assign done    = done_q;
   assign result  = res_q;
   assign ffr_out = ffr_q;

   // R7: a pending request is held with a stable address
   p_req_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

   // R8: completion is a single-cycle pulse that follows a busy cycle
   p_done_pulse_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_after_busy_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

   // R5: during an operation the mask only loses bits
   p_ffr_only_clears_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ((ffr_q & ~$past(ffr_q)) == '0));

   // R6: uncertainty never goes away within one operation
   p_unknown_sticky_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && unknown_q) |=> (unknown_q || !busy));
endmodule

// File: tb/nf_vload_seq_test.sv
module nf_vload_seq_test;
   localparam int VLEN = 128;
   localparam int NB   = VLEN / 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_valid = 1'b0;
   logic [63:0]     start_base = '0;
   logic [3:0]      start_imm = '0;
   logic [1:0]      start_esz = '0;
   logic [NB-1:0]   start_pred = '0;
   logic [NB-1:0]   start_ffr = '0;
   logic [VLEN-1:0] start_old = '0;
   logic            busy, req_valid, done;
   logic            req_ready = 1'b0;
   logic [63:0]     req_addr;
   logic            rsp_valid = 1'b0;
   logic [7:0]      rsp_data = '0;
   logic            rsp_fault = 1'b0;
   logic [VLEN-1:0] result;
   logic [NB-1:0]   ffr_out;

   nf_vload_seq #(.VLEN(VLEN)) uut (
      .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_base(start_base),
      .start_imm(start_imm), .start_esz(start_esz), .start_pred(start_pred),
      .start_ffr(start_ffr), .start_old(start_old), .busy(busy),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fault(rsp_fault),
      .done(done), .result(result), .ffr_out(ffr_out)
   );

   always #2 clk = ~clk;   // 250 MHz

   int n_chk = 0;
   int n_bad = 0;
   logic [63:0] flt_lo = '1;
   logic [63:0] flt_hi = '0;
   logic [63:0] got_addr [32];
   int          got_n = 0;
   logic [63:0] exp_addr [NB];
   int          exp_n;
   logic [VLEN-1:0] exp_res;
   logic [NB-1:0]   exp_ffr;

   function automatic logic [7:0] mem_byte(input logic [63:0] a);
      return a[7:0] ^ a[23:16] ^ a[47:40] ^ 8'hA5;
   endfunction

   function automatic logic mem_fault(input logic [63:0] a);
      return (a >= flt_lo) && (a <= flt_hi);
   endfunction

   function automatic logic [63:0] elem_addr(input logic [63:0] base, input logic [3:0] imm,
                                             input int nel, input int e);
      logic signed [63:0] s;
      s = {{60{imm[3]}}, imm};
      return base + 64'(s * 64'(nel)) + 64'(e);
   endfunction

   task automatic model(input logic [63:0] base, input logic [3:0] imm, input logic [1:0] esz,
                        input logic [NB-1:0] pred, input logic [NB-1:0] ffr);
      int eb, nel, lb;
      logic faulted, unknown, act, f;
      logic [7:0] d;
      logic [63:0] a;
      eb = 1 << esz;
      nel = NB >> esz;
      faulted = 0; unknown = 0;
      exp_ffr = ffr; exp_res = '0; exp_n = 0;
      for (int e = 0; e < nel; e++) begin
         lb = e * eb;
         act = pred[lb];
         a = elem_addr(base, imm, nel, e);
         if (act) begin
            exp_addr[exp_n] = a; exp_n++;
            d = mem_byte(a); f = mem_fault(a);
         end else begin
            d = 8'h00; f = 1'b0;
         end
         faulted = faulted | f;
         if (faulted) for (int k = 0; k < eb; k++) exp_ffr[lb + k] = 1'b0;
         unknown = unknown | ~exp_ffr[lb];
         if (!unknown) exp_res[lb*8 +: 8] = d;
      end
   endtask

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // memory responder: random ready and latency
   initial begin
      forever begin
         @(negedge clk);
         req_ready = ($urandom % 3) != 0;
         if (req_valid && req_ready) begin
            logic [63:0] a;
            a = req_addr;
            if (got_n < 32) got_addr[got_n] = a;
            got_n++;
            @(negedge clk);
            req_ready = 1'b0;
            repeat ($urandom % 3) @(negedge clk);
            rsp_valid = 1'b1;
            rsp_data  = mem_byte(a);
            rsp_fault = mem_fault(a);
            @(negedge clk);
            rsp_valid = 1'b0;
            rsp_fault = 1'b0;
            rsp_data  = 8'h00;
         end
      end
   end

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog: done=0 expected 1");
      summary();
   end

   task automatic run_op(input logic [63:0] base, input logic [3:0] imm, input logic [1:0] esz,
                         input logic [NB-1:0] pred, input logic [NB-1:0] ffr, input string tag);
      logic [VLEN-1:0] old;
      old = {$urandom, $urandom, $urandom, $urandom};
      model(base, imm, esz, pred, ffr);
      got_n = 0;
      @(negedge clk);
      start_valid = 1'b1; start_base = base; start_imm = imm; start_esz = esz;
      start_pred = pred; start_ffr = ffr; start_old = old;
      @(negedge clk);
      // R8: a start while busy must be ignored
      chk(busy, "R8", {tag, " busy after start"}, VLEN'(busy), VLEN'(1));
      start_base = ~base; start_pred = ~pred; start_ffr = ~ffr; start_esz = ~esz;
      @(negedge clk);
      start_valid = 1'b0;
      while (!done) @(negedge clk);
      chk(result == exp_res, "R3", {tag, " result"}, result, exp_res);
      chk(ffr_out == exp_ffr, "R5", {tag, " ffr"}, VLEN'(ffr_out), VLEN'(exp_ffr));
      chk(got_n == exp_n, "R2", {tag, " read count"}, VLEN'(got_n), VLEN'(exp_n));
      for (int i = 0; i < exp_n && i < got_n && i < 32; i++)
         chk(got_addr[i] == exp_addr[i], "R1", {tag, " address order R7"},
             VLEN'(got_addr[i]), VLEN'(exp_addr[i]));
      @(negedge clk);
      chk(!done && !busy, "R8", {tag, " done pulse"}, VLEN'({done, busy}), VLEN'(0));
   endtask

   initial begin
      logic [63:0] b;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(!busy && !done && !req_valid, "R9", "control at reset",
          VLEN'({busy, done, req_valid}), VLEN'(0));
      chk(result == '0 && ffr_out == '0, "R9", "data at reset", result, '0);
      rst_n = 1'b1;

      // R2: no active element
      run_op(64'h1000, 4'd0, 2'b00, '0, '1, "R2 empty");
      // R4 sizes, R1 immediates at both ends
      for (int s = 0; s < 4; s++) begin
         run_op(64'h0000_0040_0000_1200, 4'd7, 2'(s), '1, '1, "R4 full +7");
         run_op(64'h0000_0040_0000_1200, 4'h8, 2'(s), '1, '1, "R1 full -8");
      end
      // R4: only lead predicate bits count
      run_op(64'h2000, 4'd1, 2'b01, 16'hAAAA, '1, "R4 nonlead pred");
      run_op(64'h2000, 4'd1, 2'b01, 16'h5555, '1, "R4 lead pred");
      // R5: fault at element 3 of byte vector
      b = 64'h3000;
      flt_lo = elem_addr(b, 4'd0, 16, 3); flt_hi = flt_lo;
      run_op(b, 4'd0, 2'b00, '1, '1, "R5 fault e3");
      // R5: fault window on an inactive element only
      flt_lo = elem_addr(b, 4'd0, 16, 5); flt_hi = flt_lo;
      run_op(b, 4'd0, 2'b00, 16'hFFDF, '1, "R2 fault on inactive");
      flt_lo = '1; flt_hi = '0;
      // R6: incoming mask zero in a lead bit, then in a non-lead bit
      run_op(64'h4000, 4'd2, 2'b01, '1, 16'hFFEF, "R6 ffr lead zero");
      run_op(64'h4000, 4'd2, 2'b01, '1, 16'hFFDF, "R6 ffr nonlead zero");
      // wrap-around of the address space
      run_op(64'hFFFF_FFFF_FFFF_FFF8, 4'd0, 2'b00, '1, '1, "R1 wrap");

      // random mix
      for (int n = 0; n < 300; n++) begin
         logic [1:0]    esz;
         logic [3:0]    imm;
         logic [NB-1:0] pred, ffr;
         esz  = 2'($urandom);
         imm  = 4'($urandom);
         b    = {$urandom, $urandom};
         pred = 16'($urandom);
         ffr  = (($urandom % 3) == 0) ? ~(16'd1 << ($urandom % 16)) : '1;
         if ($urandom % 2) begin
            flt_lo = elem_addr(b, imm, NB >> esz, int'($urandom % (NB >> esz)));
            flt_hi = flt_lo + 64'($urandom % 4);
         end else begin
            flt_lo = '1; flt_hi = '0;
         end
         run_op(b, imm, esz, pred, ffr, "R6 random");
      end
      summary();
   end
endmodule